// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Write-Back Status

This block caches virtual-to-physical page translations in a small, fully associative store. Any translation can occupy any slot. A lookup compares the presented virtual page number against every valid slot in the same cycle. It returns a hit flag and the physical page number combinationally.

Each slot keeps a valid bit, a referenced bit and a modified (dirty) bit. These status bits are updated locally on every hit. They are reported to the page-table side only when a slot is displaced by a fill or swept out by a flush. A fill takes the lowest-numbered empty slot when there is one. If no slot is empty, the fill replaces a slot picked by a free-running LFSR. A fill for a page that is already resident rewrites that slot in place.

A flush walks the slots in index order and reports each one that carries status. It then empties the whole store in one step. Page-table walks, fault handling and address-space identifiers are handled elsewhere.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is empty, `lk_hit` is 0, `lk_ppn` is 0, `wb_valid` is 0 and `busy` is 0.
- R2: While `busy` is low, a lookup whose `lk_vpn` equals the tag of a valid slot drives `lk_hit`=1 and that slot's physical page on `lk_ppn` in the same cycle. Otherwise `lk_hit`=0 and `lk_ppn`=0.
- R3: A read hit (`lk_wr`=0) sets the slot's referenced bit. A write hit (`lk_wr`=1) sets both its referenced and dirty bits. These bits become visible only through a write-back.
- R4: A fill for a page that is not resident, when at least one slot is empty, goes into the lowest-numbered empty slot. A new slot starts with referenced and dirty bits clear.
- R5: A fill when all slots are valid replaces slot `lfsr[log2(ENTRIES)-1:0]`. The 8-bit LFSR is set to 8'h01 by reset and advances on every clock edge after reset as `lfsr <= {lfsr[6:0], lfsr[7]^lfsr[5]^lfsr[4]^lfsr[3]}`. The victim is chosen from the value before the edge.
- R6: A fill whose `fill_vpn` matches a valid slot rewrites that slot with the new physical page and clear status. No second copy is created.
- R7: When a fill replaces a valid slot whose referenced or dirty bit is set, the next cycle carries a one-cycle `wb_valid` pulse. That pulse carries the old slot's tag, physical page, referenced and dirty bits. Replacing a clean slot gives no pulse.
- R8: A flush accepted while idle raises `busy` for ENTRIES cycles. On the k-th of those edges slot k-1 is examined. Each examined slot that is valid with referenced or dirty set is written back the cycle after it is examined. After the last examined slot, every slot is empty.
- R9: While `busy` is high, lookups miss and update nothing, and fill and flush requests are ignored. A fill presented in the same cycle as an accepted flush is also ignored.
- R10: When a lookup hits the slot that a same-cycle fill replaces, the write-back reports the status including that hit's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is a store access |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page on hit, else 0 |
| fill_req | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page to install |
| fill_ppn | input | PPN_W | Physical page to install |
| flush_req | input | 1 | Start a flush |
| busy | output | 1 | Flush in progress |
| wb_valid | output | 1 | Status write-back pulse |
| wb_vpn | output | VPN_W | Virtual page of written-back slot |
| wb_ppn | output | PPN_W | Physical page of written-back slot |
| wb_ref | output | 1 | Referenced bit written back |
| wb_dirty | output | 1 | Dirty bit written back |

## Verification
The hardest case to reach is random replacement of a slot whose status was just changed. The victim depends on an internal LFSR that cannot be seen from the ports. The bench therefore keeps its own copy of the LFSR sequence, counted from reset, and predicts every victim. It fills all slots and references each one, so later fills must evict a slot and write it back.

A deliberate same-cycle write hit and refill of one page covers R10. Requests issued during a flush show that nothing leaks in. Whether such a request was ignored is confirmed by later lookups that miss.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

  // x^8 + x^6 + x^5 + x^4 + 1, shift toward the MSB
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     vld,
  output logic [IDX_W-1:0] pick
);
  import xlat_pkg::*;

  logic [LFSR_W-1:0] lfsr_q;
  logic              has_free;
  logic [IDX_W-1:0]  free_idx;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    pick = has_free ? free_idx : lfsr_q[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_next(lfsr_q);
  end

  // R4: an empty slot is always taken before a valid one
  p_free_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    has_free |-> !vld[pick]);
  // R5: the pseudo-random source never locks up at zero
  p_lfsr_alive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic             lk_wr,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_req,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush_req,
  output logic             busy,
  output logic             wb_valid,
  output logic [VPN_W-1:0] wb_vpn,
  output logic [PPN_W-1:0] wb_ppn,
  output logic             wb_ref,
  output logic             wb_dirty
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            vld_q, ref_q, drt_q;
  logic [ENTRIES-1:0]            ref_nx, drt_nx;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic                          busy_q;
  logic [IDX_W-1:0]              sweep_idx;

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [IDX_W-1:0]   rand_pick, dup_idx, slot;
  logic               fill_go, evict_wb, sweep_wb, sweep_last;

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W)) i_lk_cmp (
    .vld(vld_q), .tags(tag_q), .key(lk_vpn), .hit(lk_match));
  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W)) i_fl_cmp (
    .vld(vld_q), .tags(tag_q), .key(fill_vpn), .hit(fl_match));
  xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) i_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .pick(rand_pick));

  // lookup result and per-slot status update
  always_comb begin
    lk_hit = lk_req && !busy_q && (|lk_match);
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit && lk_match[i]) lk_ppn = lk_ppn | ppn_q[i];
      ref_nx[i] = ref_q[i] | (lk_hit & lk_match[i]);
      drt_nx[i] = drt_q[i] | (lk_hit & lk_wr & lk_match[i]);
    end
  end

  // fill target: resident copy first, otherwise the victim picker
  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fl_match[i]) dup_idx = IDX_W'(i);
    slot     = (|fl_match) ? dup_idx : rand_pick;
    fill_go  = fill_req && !busy_q && !flush_req;
    evict_wb = fill_go && vld_q[slot] && (ref_nx[slot] || drt_nx[slot]);
    sweep_wb = busy_q && vld_q[sweep_idx] && (ref_q[sweep_idx] || drt_q[sweep_idx]);
    sweep_last = (sweep_idx == IDX_W'(ENTRIES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      ref_q     <= '0;
      drt_q     <= '0;
      tag_q     <= '0;
      ppn_q     <= '0;
      busy_q    <= 1'b0;
      sweep_idx <= '0;
      wb_valid  <= 1'b0;
      wb_vpn    <= '0;
      wb_ppn    <= '0;
      wb_ref    <= 1'b0;
      wb_dirty  <= 1'b0;
    end else begin
      wb_valid <= 1'b0;
      ref_q    <= ref_nx;
      drt_q    <= drt_nx;
      if (busy_q) begin
        if (sweep_wb) begin
          wb_valid <= 1'b1;
          wb_vpn   <= tag_q[sweep_idx];
          wb_ppn   <= ppn_q[sweep_idx];
          wb_ref   <= ref_q[sweep_idx];
          wb_dirty <= drt_q[sweep_idx];
        end
        if (sweep_last) begin
          vld_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          sweep_idx <= sweep_idx + 1'b1;
        end
      end else if (flush_req) begin
        busy_q    <= 1'b1;
        sweep_idx <= '0;
      end else if (fill_go) begin
        if (evict_wb) begin
          wb_valid <= 1'b1;
          wb_vpn   <= tag_q[slot];
          wb_ppn   <= ppn_q[slot];
          wb_ref   <= ref_nx[slot];
          wb_dirty <= drt_nx[slot];
        end
        vld_q[slot] <= 1'b1;
        tag_q[slot] <= fill_vpn;
        ppn_q[slot] <= fill_ppn;
        ref_q[slot] <= 1'b0;
        drt_q[slot] <= 1'b0;
      end
    end
  end

  assign busy = busy_q;

  // R6: a page is never resident in two slots
  p_unique_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(fl_match));
  // R7: write-back only ever carries a slot with status set
  p_wb_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_ref || wb_dirty));
  // R9: no hit is reported while sweeping
  p_busy_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_hit);
  // R8: the store is empty once the sweep ends
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (vld_q == '0));
  // R2: a hit returns a page that was installed in a valid slot
  p_hit_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (|(lk_match & vld_q)));
endmodule

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;
  localparam int N = 8;
  localparam int VW = 20;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 0, lk_wr = 0, fill_req = 0, flush_req = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic lk_hit, busy, wb_valid, wb_ref, wb_dirty;
  logic [PW-1:0] lk_ppn, wb_ppn;
  logic [VW-1:0] wb_vpn;

  always #2.5 clk = ~clk;

  xlat_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) i_xlat_tlb (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_wr(lk_wr), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .fill_req(fill_req), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .flush_req(flush_req), .busy(busy), .wb_valid(wb_valid),
    .wb_vpn(wb_vpn), .wb_ppn(wb_ppn), .wb_ref(wb_ref), .wb_dirty(wb_dirty));

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference state
  int m_vld[N], m_ref[N], m_drt[N], m_tag[N], m_ppn[N];
  int m_lfsr, m_busy, m_idx;
  int e_wbv, e_wbvpn, e_wbppn, e_wbr, e_wbd;
  int wb_seen;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find(int vpn);
    for (int i = 0; i < N; i++) if (m_vld[i] != 0 && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int step_lfsr(int l);
    int fb;
    fb = ((l >> 7) ^ (l >> 5) ^ (l >> 4) ^ (l >> 3)) & 1;
    return ((l << 1) & 255) | fb;
  endfunction

  task automatic cyc(string req, bit lr, bit lw, int lv, bit fr, int fv, int fp, bit fl);
    int h, slot, n_ref, n_drt;
    lk_req = lr; lk_wr = lw; lk_vpn = VW'(lv);
    fill_req = fr; fill_vpn = VW'(fv); fill_ppn = PW'(fp); flush_req = fl;
    #1;
    h = (lr && m_busy == 0) ? find(lv) : -1;
    check(req, "lk_hit", int'(lk_hit), (h >= 0) ? 1 : 0);
    check(req, "lk_ppn", int'(lk_ppn), (h >= 0) ? m_ppn[h] : 0);
    @(posedge clk);
    e_wbv = 0;
    if (h >= 0) begin
      m_ref[h] = 1;
      if (lw) m_drt[h] = 1;
    end
    if (m_busy != 0) begin
      if (m_vld[m_idx] != 0 && (m_ref[m_idx] != 0 || m_drt[m_idx] != 0)) begin
        e_wbv = 1; e_wbvpn = m_tag[m_idx]; e_wbppn = m_ppn[m_idx];
        e_wbr = m_ref[m_idx]; e_wbd = m_drt[m_idx];
      end
      if (m_idx == N - 1) begin
        for (int i = 0; i < N; i++) m_vld[i] = 0;
        m_busy = 0;
      end else m_idx++;
    end else if (fl) begin
      m_busy = 1; m_idx = 0;
    end else if (fr) begin
      slot = find(fv);
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (m_vld[i] == 0) slot = i;
      if (slot < 0) slot = m_lfsr & (N - 1);
      if (m_vld[slot] != 0 && (m_ref[slot] != 0 || m_drt[slot] != 0)) begin
        e_wbv = 1; e_wbvpn = m_tag[slot]; e_wbppn = m_ppn[slot];
        e_wbr = m_ref[slot]; e_wbd = m_drt[slot];
      end
      m_vld[slot] = 1; m_tag[slot] = fv; m_ppn[slot] = fp; m_ref[slot] = 0; m_drt[slot] = 0;
    end
    m_lfsr = step_lfsr(m_lfsr);
    @(negedge clk);
    check(req, "busy", int'(busy), m_busy);
    check(req, "wb_valid", int'(wb_valid), e_wbv);
    if (e_wbv != 0) begin
      wb_seen++;
      check(req, "wb_vpn", int'(wb_vpn), e_wbvpn);
      check(req, "wb_ppn", int'(wb_ppn), e_wbppn);
      check(req, "wb_ref", int'(wb_ref), e_wbr);
      check(req, "wb_dirty", int'(wb_dirty), e_wbd);
    end
  endtask

  task automatic idle(string req, int n);
    for (int k = 0; k < n; k++) cyc(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string req, int v, int p);
    cyc(req, 0, 0, 0, 1, v, p, 0);
  endtask

  task automatic look(string req, bit w, int v);
    cyc(req, 1, w, v, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_ref[i] = 0; m_drt[i] = 0; m_tag[i] = 0; m_ppn[i] = 0;
    end
    m_lfsr = 1; m_busy = 0; m_idx = 0; wb_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "lk_hit", int'(lk_hit), 0);
    check("R1", "wb_valid", int'(wb_valid), 0);
    check("R1", "busy", int'(busy), 0);
    look("R1", 0, 'h123);
    idle("R1", 2);
    // R2 / R4: fills into empty slots, hits and misses
    fill("R4", 'h100, 'hA0);
    fill("R4", 'h200, 'hB0);
    fill("R4", 'h300, 'hC0);
    look("R2", 0, 'h200);
    look("R2", 0, 'h999);
    // R3: read hit and write hit
    look("R3", 0, 'h100);
    look("R3", 1, 'h200);
    // R8 / R9: flush with requests arriving during it
    cyc("R9", 0, 0, 0, 1, 'h777, 'h77, 1);
    look("R9", 0, 'h100);
    fill("R9", 'h555, 'h55);
    cyc("R9", 0, 0, 0, 0, 0, 0, 1);
    idle("R8", N);
    look("R8", 0, 'h100);
    look("R9", 0, 'h555);
    look("R9", 0, 'h777);
    // R4 / R5 / R7: fill all slots, reference each, then evict randomly
    for (int i = 0; i < N; i++) fill("R4", 'h1000 + i, 'h10 + i);
    for (int i = 0; i < N; i++) look("R3", (i % 2) == 1, 'h1000 + i);
    for (int i = 0; i < 4; i++) fill("R5", 'h2000 + i, 'h40 + i);
    for (int i = 0; i < 4; i++) look("R5", 0, 'h2000 + i);
    // R6: refill of a resident page after a write hit
    look("R6", 1, 'h2001);
    fill("R6", 'h2001, 'h99);
    look("R6", 0, 'h2001);
    fill("R6", 'h2001, 'h9A);
    // R10: same-cycle write hit on the slot being refilled
    cyc("R10", 1, 1, 'h2002, 1, 'h2002, 'h88, 0);
    look("R10", 0, 'h2002);
    // R7: evict clean slots
    for (int i = 0; i < 6; i++) fill("R7", 'h3000 + i, 'h60 + i);
    // random traffic
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 19);
      if (op == 0) cyc("R8", 0, 0, 0, 0, 0, 0, 1);
      else cyc("R5", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
               'h4000 + $urandom_range(0, 15), $urandom_range(0, 2) == 0,
               'h4000 + $urandom_range(0, 15), $urandom_range(0, 'hFFFF), 0);
    end
    idle("R8", N + 2);
    check("R7", "write-backs observed", int'(wb_seen > 5), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule